// File: doc/BRIEF.md
# Open-Drain Port Expander Register Core

This block keeps the register state of an eight-pin expander whose pins are open-drain with a pull-up. Each pin either sinks current or floats high. Software-side logic reaches four byte-wide registers through a small internal port: a write strobe, a two-bit register select, write data and combinational read data. The pad levels enter on an eight-bit input. The block resolves a level for every pin and drives an eight-bit sink-enable vector back to the pads. It also drives one level-follow line for each pin, and that line moves only when the resolved level of its pin changes.

A pin sinks only when its direction bit selects output and its drive bit is 0. In every other case the pin floats and the pad decides its level. The level register can be read with a per-bit inversion mask applied. The serial bus that would feed the register port sits outside this core.

Top module: `gpio_xpndr_core`

## Requirements
- R1: After the synchronous active-high reset the register port reads 0xFF at select 0 (level), 0xFF at select 1 (drive), 0x00 at select 2 (invert mask) and 0xFF at select 3 (direction). At the same time `sink_o` is 0x00 and `follow_o` is 0xFF.
- R2: Values written at selects 1, 2 and 3 read back unchanged at the same select.
- R3: `sink_o[i]` is 1 exactly when direction bit i is 0 (output) and drive bit i is 0.
- R4: A sinking pin resolves to level 0 whatever its pad level is.
- R5: A floating pin resolves to its pad level: 1 when the pad is released (high) and 0 when the pad is pulled low.
- R6: A read at select 0 returns the resolved level bits XOR the invert mask.
- R7: A write at select 0 has no effect on any register.
- R8: A write to the invert mask changes neither the resolved level bits nor `follow_o`.
- R9: A pad change reaches the level read-back on the third rising clock edge after it is applied, and not earlier.
- R10: A write to the drive or direction register shows on `sink_o` right after its write edge, and shows in the resolved levels after one more clock edge.
- R11: `follow_o[i]` takes the new resolved level of pin i when that level changes, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| we | input | 1 | Register write strobe |
| addr | input | 2 | Register select (0 level, 1 drive, 2 invert mask, 3 direction) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register, combinational |
| pad_lvl | input | 8 | Pad levels, asynchronous |
| sink_o | output | 8 | Per-pin sink enable (1 = pull the pad low) |
| follow_o | output | 8 | Per-pin level-follow lines |

## Verification
Each result is due at a fixed distance from its stimulus. `sink_o` and the register read-back follow a write on its own write edge. The resolved level and `follow_o` follow one edge after that. A pad change needs three edges: two synchronizer stages and then the level register. The bench drives every input on the falling edge and counts the rising edges before it samples. For R9 it samples once before the due edge, where the old value is expected, and once after it.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
    typedef enum logic [1:0] {
        GPX_LVL  = 2'd0,
        GPX_DRV  = 2'd1,
        GPX_INV  = 2'd2,
        GPX_DIR  = 2'd3
    } gpx_sel_e;
endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
    parameter int W       = 8,
    parameter int STAGES  = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '1;
        else     stg[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[s] <= '1;
            else     stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gpx_regs.sv
module gpx_regs
    import gpx_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [1:0]       addr,
    input  logic [NPINS-1:0] wdata,
    input  logic [NPINS-1:0] lvl_q,
    output logic [NPINS-1:0] drv_q,
    output logic [NPINS-1:0] dir_q,
    output logic [NPINS-1:0] inv_q,
    output logic [NPINS-1:0] rdata
);
    gpx_sel_e sel;
    assign sel = gpx_sel_e'(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            drv_q <= '1;
            dir_q <= '1;
            inv_q <= '0;
        end else if (we) begin
            unique case (sel)
                GPX_DRV: drv_q <= wdata;
                GPX_INV: inv_q <= wdata;
                GPX_DIR: dir_q <= wdata;
                GPX_LVL: ;
            endcase
        end
    end

    always_comb begin
        unique case (sel)
            GPX_LVL: rdata = lvl_q ^ inv_q;
            GPX_DRV: rdata = drv_q;
            GPX_INV: rdata = inv_q;
            GPX_DIR: rdata = dir_q;
        endcase
    end
endmodule

// File: rtl/gpx_resolve.sv
module gpx_resolve #(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] drv_q,
    input  logic [NPINS-1:0] dir_q,
    input  logic [NPINS-1:0] pad_s,
    output logic [NPINS-1:0] sink,
    output logic [NPINS-1:0] lvl_q,
    output logic [NPINS-1:0] follow_q
);
    logic [NPINS-1:0] lvl_nxt;

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        assign sink[i]    = ~(dir_q[i] | drv_q[i]);
        assign lvl_nxt[i] = sink[i] ? 1'b0 : pad_s[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q    <= '1;
            follow_q <= '1;
        end else begin
            lvl_q <= lvl_nxt;
            for (int i = 0; i < NPINS; i++) begin
                if (lvl_nxt[i] != lvl_q[i]) follow_q[i] <= lvl_nxt[i];
            end
        end
    end
endmodule

// File: rtl/gpio_xpndr_core.sv
module gpio_xpndr_core #(
    parameter int NPINS       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [1:0]       addr,
    input  logic [NPINS-1:0] wdata,
    output logic [NPINS-1:0] rdata,
    input  logic [NPINS-1:0] pad_lvl,
    output logic [NPINS-1:0] sink_o,
    output logic [NPINS-1:0] follow_o
);
    logic [NPINS-1:0] pad_s;
    logic [NPINS-1:0] drv_q;
    logic [NPINS-1:0] dir_q;
    logic [NPINS-1:0] inv_q;
    logic [NPINS-1:0] lvl_q;

    gpx_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(pad_lvl), .q(pad_s)
    );

    gpx_regs #(.NPINS(NPINS)) u_regs (
        .clk(clk), .rst(rst), .we(we), .addr(addr), .wdata(wdata),
        .lvl_q(lvl_q), .drv_q(drv_q), .dir_q(dir_q), .inv_q(inv_q),
        .rdata(rdata)
    );

    gpx_resolve #(.NPINS(NPINS)) u_res (
        .clk(clk), .rst(rst), .drv_q(drv_q), .dir_q(dir_q), .pad_s(pad_s),
        .sink(sink_o), .lvl_q(lvl_q), .follow_q(follow_o)
    );
endmodule

// File: rtl/gpx_chk.sv
module gpx_chk #(
    parameter int NPINS = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             we,
    input logic [1:0]       addr,
    input logic [NPINS-1:0] wdata,
    input logic [NPINS-1:0] sink_o,
    input logic [NPINS-1:0] follow_o,
    input logic [NPINS-1:0] drv_q,
    input logic [NPINS-1:0] dir_q,
    input logic [NPINS-1:0] inv_q,
    input logic [NPINS-1:0] lvl_q
);
    AST_RESET_VALUES: assert property (@(posedge clk)
        rst |=> (drv_q == '1 && dir_q == '1 && inv_q == '0 && lvl_q == '1)); // R1

    AST_DRV_STORE: assert property (@(posedge clk) disable iff (rst)
        (we && addr == 2'd1) |=> (drv_q == $past(wdata))); // R2

    AST_SINK_FORCES_LOW: assert property (@(posedge clk) disable iff (rst)
        (sink_o != '0) |=> ((lvl_q & $past(sink_o)) == '0)); // R4

    AST_LVL_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (we && addr == 2'd0) |=> ($stable(drv_q) && $stable(dir_q) && $stable(inv_q))); // R7

    AST_FOLLOW_ON_CHANGE: assert property (@(posedge clk) disable iff (rst)
        !$stable(follow_o) |-> (follow_o == lvl_q)); // R11
endmodule

bind gpio_xpndr_core gpx_chk #(.NPINS(NPINS)) u_chk (
    .clk(clk), .rst(rst), .we(we), .addr(addr), .wdata(wdata),
    .sink_o(sink_o), .follow_o(follow_o),
    .drv_q(drv_q), .dir_q(dir_q), .inv_q(inv_q), .lvl_q(lvl_q)
);

// File: tb/gpio_xpndr_core_tb_top.sv
module gpio_xpndr_core_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       we = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [7:0] pad_lvl = 8'hFF;
    logic [7:0] sink_o;
    logic [7:0] follow_o;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_xpndr_core dut_i (
        .clk(clk), .rst(rst), .we(we), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pad_lvl(pad_lvl), .sink_o(sink_o), .follow_o(follow_o)
    );

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; pad_lvl = 8'hFF; we = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        do_reset();
        rd(2'd0, v); chk("R1 level", v, 8'hFF);
        rd(2'd1, v); chk("R1 drive", v, 8'hFF);
        rd(2'd2, v); chk("R1 invert", v, 8'h00);
        rd(2'd3, v); chk("R1 direction", v, 8'hFF);
        chk("R1 sink", sink_o, 8'h00);
        chk("R1 follow", follow_o, 8'hFF);
    endtask

    task automatic t_readback();
        logic [7:0] v;
        do_reset();
        wr(2'd1, 8'h3C); wr(2'd2, 8'hA5); wr(2'd3, 8'h96);
        rd(2'd1, v); chk("R2 drive", v, 8'h3C);
        rd(2'd2, v); chk("R2 invert", v, 8'hA5);
        rd(2'd3, v); chk("R2 direction", v, 8'h96);
    endtask

    task automatic t_sink_resolve();
        logic [7:0] v;
        do_reset();
        wr(2'd1, 8'h05); wr(2'd3, 8'hF0);
        chk("R3 sink", sink_o, 8'h0A);
        repeat (2) @(negedge clk);
        rd(2'd0, v); chk("R4 sinking pins low", v, 8'hF5);
        pad_lvl = 8'h55;
        repeat (4) @(negedge clk);
        rd(2'd0, v); chk("R5 floating follow pad", v, 8'h55);
        pad_lvl = 8'hFF;
    endtask

    task automatic t_invert();
        logic [7:0] v;
        logic [7:0] f;
        do_reset();
        pad_lvl = 8'hF0;
        repeat (4) @(negedge clk);
        f = follow_o;
        wr(2'd2, 8'h3C);
        repeat (2) @(negedge clk);
        rd(2'd0, v); chk("R6 inverted read", v, 8'hCC);
        chk("R8 follow unchanged", follow_o, f);
        wr(2'd2, 8'h00);
        rd(2'd0, v); chk("R8 level unchanged", v, 8'hF0);
    endtask

    task automatic t_lvl_write();
        logic [7:0] v;
        do_reset();
        wr(2'd3, 8'h7E); wr(2'd1, 8'h81); wr(2'd2, 8'h11);
        wr(2'd0, 8'h00);
        rd(2'd1, v); chk("R7 drive kept", v, 8'h81);
        rd(2'd2, v); chk("R7 invert kept", v, 8'h11);
        rd(2'd3, v); chk("R7 direction kept", v, 8'h7E);
        rd(2'd0, v); chk("R7 level kept", v, 8'hFF ^ 8'h11);
    endtask

    task automatic t_pad_latency();
        logic [7:0] v;
        do_reset();
        @(negedge clk);
        pad_lvl = 8'hFB;
        repeat (2) @(negedge clk);
        rd(2'd0, v); chk("R9 not before third edge", v, 8'hFF);
        chk("R11 follow held", follow_o, 8'hFF);
        @(negedge clk);
        rd(2'd0, v); chk("R9 at third edge", v, 8'hFB);
        chk("R11 follow falls", follow_o, 8'hFB);
        pad_lvl = 8'hFF;
        repeat (3) @(negedge clk);
        chk("R11 follow rises", follow_o, 8'hFF);
    endtask

    task automatic t_write_latency();
        logic [7:0] v;
        do_reset();
        wr(2'd1, 8'hFE);
        chk("R10 sink after drive write", sink_o, 8'h00);
        wr(2'd3, 8'hFE);
        chk("R10 sink after direction write", sink_o, 8'h01);
        rd(2'd0, v); chk("R10 level not yet", v, 8'hFF);
        @(negedge clk);
        rd(2'd0, v); chk("R10 level one edge later", v, 8'hFE);
        chk("R11 follow after write", follow_o, 8'hFE);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_readback();
        t_sink_resolve();
        t_invert();
        t_lvl_write();
        t_pad_latency();
        t_write_latency();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule